// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits at the head of an Ethernet receive path and decides, from the destination address at the start of each frame, whether the frame should be kept. Header bytes arrive one per cycle when `rx_valid` is high, and `rx_sof` marks the first of them. Each byte is compared with the station address, checked for all-ones and folded into a running LSB-first CRC-32 as it arrives. After the sixth byte the block gives a single-cycle verdict. The verdict says accept or reject, together with the reason for it.

Software sets the filter through a write-only 32-bit register port. The port holds a configuration word (receive enable, promiscuous, hash enable), the 48-bit station address as three 16-bit words, and a 64-bit multicast hash table as four 16-bit words. At start-of-frame the block copies every register into a per-frame snapshot. A write that lands while a frame is in progress therefore only affects the frames that follow.

Top module: `rx_dest_filter`

## Requirements
- R1: Register word addresses: 0 is configuration (bit 0 receive enable, bit 1 promiscuous, bit 2 hash enable); 1, 2 and 3 hold station words 0, 1 and 2 in data bits 15:0; 4 to 7 hold hash table words, with table word 0 at address 7, word 1 at 6, word 2 at 5 and word 3 at 4. All registers reset to zero.
- R2: When receive enable is clear, the frame is rejected with reason 5 (disabled), whatever the other bits and the address are.
- R3: When receive is enabled and promiscuous is set, the frame is accepted with reason 4 (promiscuous), ahead of every address check.
- R4: Station word k is compared with header bytes 2k and 2k+1. Its bits 15:8 match byte 2k and its bits 7:0 match byte 2k+1. A full match accepts with reason 1 (local), ahead of broadcast and hash.
- R5: An all-ones destination that does not match the station address is accepted with reason 2 (broadcast), ahead of the hash check.
- R6: With hash enable set and no station or broadcast match, the hash index is taken from the top 6 bits of a CRC-32 over the six bytes. The CRC is LSB-first, uses polynomial 0xEDB88320, starts at all ones and is not inverted at the end. When the indexed table bit is set, the frame is accepted with reason 3 (hash).
- R7: Index bits 5:4 choose the hash table word and bits 3:0 choose the bit within it. A bit set in any other register word has no effect.
- R8: A frame that matches nothing, or that only hashes while hash enable is clear, is rejected with reason 0 (no match).
- R9: `flt_valid` pulses for exactly one cycle, in the cycle after the sixth header byte is taken. Idle cycles between bytes are allowed. Bytes after the sixth produce no further verdict until the next `rx_sof`.
- R10: Register contents are captured at `rx_sof`. A write during a frame does not change that frame's verdict, and it applies from the next frame.
- R11: After reset `flt_valid` is low, and a frame sent before any register write is rejected as disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 3 | Register word address |
| cfg_wr_data | input | 32 | Register write data |
| rx_sof | input | 1 | First header byte marker, valid with rx_valid |
| rx_valid | input | 1 | Header byte present |
| rx_byte | input | 8 | Header byte |
| flt_valid | output | 1 | One-cycle verdict strobe |
| flt_accept | output | 1 | Frame accepted |
| flt_reason | output | 3 | 0 no match, 1 local, 2 broadcast, 3 hash, 4 promiscuous, 5 disabled |

## Verification
A register write takes effect at the clock edge that follows the write. The verdict for a frame appears exactly one edge after the edge that takes the sixth header byte. The bench drives each input on a falling edge. It samples `flt_valid`, `flt_accept` and `flt_reason` on the falling edge that directly follows the sixth byte, and it also checks that no strobe appeared earlier. After that point, a counter of strobes taken on falling edges shows that trailing bytes produce no second verdict. The same counter shows that the strobe lasts one cycle and that gaps between bytes only shift the verdict.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_BYTES    = 6;
    localparam int STA_W         = 8 * ADDR_BYTES;
    localparam int CRC_W         = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB88320;
    localparam int TBL_WORD_W    = 16;
    localparam int STA_WORDS     = STA_W / TBL_WORD_W;
    localparam int REG_CFG       = 0;
    localparam int REG_STA_BASE  = 1;
    localparam int REG_HASH_BASE = REG_STA_BASE + STA_WORDS;

    typedef enum logic [2:0] {
        RSN_NOMATCH  = 3'd0,
        RSN_LOCAL    = 3'd1,
        RSN_BCAST    = 3'd2,
        RSN_HASH     = 3'd3,
        RSN_PROMISC  = 3'd4,
        RSN_DISABLED = 3'd5
    } rxf_reason_e;

    typedef struct packed {
        logic hash_en;
        logic promisc;
        logic rx_en;
    } rxf_cfg_t;
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
    import rxf_pkg::*;
#(
    parameter int HASH_IDX_W = 6,
    parameter int REG_DW     = 32,
    parameter int REG_AW     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [REG_AW-1:0]           wr_addr,
    input  logic [REG_DW-1:0]           wr_data,
    output rxf_cfg_t                    cfg_o,
    output logic [STA_W-1:0]            sta_o,
    output logic [(1<<HASH_IDX_W)-1:0]  tbl_o
);
    localparam int TBL_BITS   = 1 << HASH_IDX_W;
    localparam int HASH_WORDS = TBL_BITS / TBL_WORD_W;

    typedef struct packed {
        rxf_cfg_t               cfg;
        logic [STA_W-1:0]       sta;
        logic [TBL_BITS-1:0]    tbl;
    } regs_t;

    regs_t regs_d, regs_q;

    logic unused_hi;
    assign unused_hi = ^wr_data[REG_DW-1:TBL_WORD_W];

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == REG_AW'(REG_CFG)) begin
                regs_d.cfg = rxf_cfg_t'(wr_data[2:0]);
            end
            for (int k = 0; k < STA_WORDS; k++) begin
                if (wr_addr == REG_AW'(REG_STA_BASE + k)) begin
                    regs_d.sta[STA_W-1-TBL_WORD_W*k -: TBL_WORD_W] = wr_data[TBL_WORD_W-1:0];
                end
            end
            for (int g = 0; g < HASH_WORDS; g++) begin
                if (wr_addr == REG_AW'(REG_HASH_BASE + HASH_WORDS - 1 - g)) begin
                    regs_d.tbl[TBL_WORD_W*g +: TBL_WORD_W] = wr_data[TBL_WORD_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg_o = regs_q.cfg;
    assign sta_o = regs_q.sta;
    assign tbl_o = regs_q.tbl;
endmodule

// File: rtl/rxf_crc8.sv
module rxf_crc8
    import rxf_pkg::*;
(
    input  logic [CRC_W-1:0] crc_i,
    input  logic [7:0]       data_i,
    output logic [CRC_W-1:0] crc_o
);
    always_comb begin
        crc_o = crc_i;
        for (int b = 0; b < 8; b++) begin
            if (crc_o[0] ^ data_i[b]) begin
                crc_o = (crc_o >> 1) ^ CRC_POLY;
            end else begin
                crc_o = crc_o >> 1;
            end
        end
    end
endmodule

// File: rtl/rxf_frame.sv
module rxf_frame
    import rxf_pkg::*;
#(
    parameter int HASH_IDX_W = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sof_i,
    input  logic                        valid_i,
    input  logic [7:0]                  byte_i,
    input  rxf_cfg_t                    cfg_i,
    input  logic [STA_W-1:0]            sta_i,
    input  logic [(1<<HASH_IDX_W)-1:0]  tbl_i,
    output logic                        vld_o,
    output logic                        acc_o,
    output rxf_reason_e                 rsn_o
);
    localparam int TBL_BITS = 1 << HASH_IDX_W;
    localparam int CNT_W    = $clog2(ADDR_BYTES + 1);

    typedef struct packed {
        logic                   active;
        logic [CNT_W-1:0]       cnt;
        rxf_cfg_t               cfg;
        logic [STA_W-1:0]       sta;
        logic [TBL_BITS-1:0]    tbl;
        logic [CRC_W-1:0]       crc;
        logic                   loc_ok;
        logic                   bc_ok;
        logic                   vld;
        logic                   acc;
        rxf_reason_e            rsn;
    } frame_t;

    frame_t st_d, st_q;

    logic                   take;
    logic                   last;
    logic [CNT_W-1:0]       idx;
    rxf_cfg_t               cfg_use;
    logic [STA_W-1:0]       sta_use;
    logic [TBL_BITS-1:0]    tbl_use;
    logic [CRC_W-1:0]       crc_base;
    logic [CRC_W-1:0]       crc_nx;
    logic                   loc_base;
    logic                   bc_base;
    logic [7:0]             sta_bytes [ADDR_BYTES];
    logic [7:0]             sta_byte;
    logic [HASH_IDX_W-1:0]  hidx;
    logic                   hit;

    assign take     = valid_i && (sof_i || st_q.active);
    assign idx      = sof_i ? '0 : st_q.cnt;
    assign last     = (idx == CNT_W'(ADDR_BYTES - 1));
    assign cfg_use  = sof_i ? cfg_i : st_q.cfg;
    assign sta_use  = sof_i ? sta_i : st_q.sta;
    assign tbl_use  = sof_i ? tbl_i : st_q.tbl;
    assign crc_base = sof_i ? '1 : st_q.crc;
    assign loc_base = sof_i ? 1'b1 : st_q.loc_ok;
    assign bc_base  = sof_i ? 1'b1 : st_q.bc_ok;

    for (genvar b = 0; b < ADDR_BYTES; b++) begin : g_sta_byte
        assign sta_bytes[b] = sta_use[STA_W-1-8*b -: 8];
    end

    assign sta_byte = sta_bytes[idx];

    rxf_crc8 u_crc (
        .crc_i  (crc_base),
        .data_i (byte_i),
        .crc_o  (crc_nx)
    );

    assign hidx = crc_nx[CRC_W-1 -: HASH_IDX_W];
    assign hit  = tbl_use[hidx];

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (take) begin
            st_d.cfg    = cfg_use;
            st_d.sta    = sta_use;
            st_d.tbl    = tbl_use;
            st_d.crc    = crc_nx;
            st_d.loc_ok = loc_base && (byte_i == sta_byte);
            st_d.bc_ok  = bc_base && (byte_i == 8'hFF);
            st_d.cnt    = idx + CNT_W'(1);
            st_d.active = !last;
            if (last) begin
                st_d.vld = 1'b1;
                if (!cfg_use.rx_en) begin
                    st_d.acc = 1'b0;
                    st_d.rsn = RSN_DISABLED;
                end else if (cfg_use.promisc) begin
                    st_d.acc = 1'b1;
                    st_d.rsn = RSN_PROMISC;
                end else if (st_d.loc_ok) begin
                    st_d.acc = 1'b1;
                    st_d.rsn = RSN_LOCAL;
                end else if (st_d.bc_ok) begin
                    st_d.acc = 1'b1;
                    st_d.rsn = RSN_BCAST;
                end else if (cfg_use.hash_en && hit) begin
                    st_d.acc = 1'b1;
                    st_d.rsn = RSN_HASH;
                end else begin
                    st_d.acc = 1'b0;
                    st_d.rsn = RSN_NOMATCH;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vld_o = st_q.vld;
    assign acc_o = st_q.acc;
    assign rsn_o = st_q.rsn;
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
    import rxf_pkg::*;
#(
    parameter  int HASH_IDX_W = 6,
    parameter  int REG_DW     = 32,
    localparam int HASH_WORDS = (1 << HASH_IDX_W) / TBL_WORD_W,
    localparam int REG_AW     = $clog2(REG_HASH_BASE + HASH_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [REG_AW-1:0] cfg_wr_addr,
    input  logic [REG_DW-1:0] cfg_wr_data,
    input  logic              rx_sof,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    output logic              flt_valid,
    output logic              flt_accept,
    output logic [2:0]        flt_reason
);
    rxf_cfg_t                   cfg_w;
    logic [STA_W-1:0]           sta_w;
    logic [(1<<HASH_IDX_W)-1:0] tbl_w;
    rxf_reason_e                rsn_w;

    rxf_cfg_regs #(
        .HASH_IDX_W (HASH_IDX_W),
        .REG_DW     (REG_DW),
        .REG_AW     (REG_AW)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_addr (cfg_wr_addr),
        .wr_data (cfg_wr_data),
        .cfg_o   (cfg_w),
        .sta_o   (sta_w),
        .tbl_o   (tbl_w)
    );

    rxf_frame #(
        .HASH_IDX_W (HASH_IDX_W)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sof_i   (rx_sof),
        .valid_i (rx_valid),
        .byte_i  (rx_byte),
        .cfg_i   (cfg_w),
        .sta_i   (sta_w),
        .tbl_i   (tbl_w),
        .vld_o   (flt_valid),
        .acc_o   (flt_accept),
        .rsn_o   (rsn_w)
    );

    assign flt_reason = rsn_w;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_sof,
    input logic       rx_valid,
    input logic       flt_valid,
    input logic       flt_accept,
    input logic [2:0] flt_reason
);
    logic [2:0] seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 3'd0;
        end else if (rx_valid && rx_sof) begin
            seen_q <= 3'd1;
        end else if (rx_valid && seen_q != 3'd0 && seen_q < 3'd6) begin
            seen_q <= seen_q + 3'd1;
        end
    end

    // R9: verdict only once six bytes of the frame have been taken
    a_r9_after_sixth: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> seen_q == 3'd6);

    // R9: sixth byte is always followed by a verdict
    a_r9_verdict_due: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_sof && seen_q == 3'd5) |=> flt_valid);

    // R9: strobe lasts one cycle
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |=> !flt_valid);

    // R3: promiscuous reason implies acceptance
    a_r3_promisc_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_reason == 3'd4) |-> flt_accept);

    // R2: disabled reason implies rejection
    a_r2_disabled_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && flt_reason == 3'd5) |-> !flt_accept);

    // R8: accept flag agrees with the class of the reason code
    a_r8_reason_class: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (flt_accept == (flt_reason >= 3'd1 && flt_reason <= 3'd4)));
endmodule

bind rx_dest_filter rxf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_sof     (rx_sof),
    .rx_valid   (rx_valid),
    .flt_valid  (flt_valid),
    .flt_accept (flt_accept),
    .flt_reason (flt_reason)
);

// File: tb/rx_dest_filter_test.sv
module rx_dest_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_addr = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        rx_sof = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        flt_valid;
    logic        flt_accept;
    logic [2:0]  flt_reason;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always #5 clk = ~clk;

    rx_dest_filter uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .rx_sof      (rx_sof),
        .rx_valid    (rx_valid),
        .rx_byte     (rx_byte),
        .flt_valid   (flt_valid),
        .flt_accept  (flt_accept),
        .flt_reason  (flt_reason)
    );

    always @(negedge clk) if (flt_valid) pulses++;

    localparam logic [47:0] STA = 48'h021122334455;
    localparam logic [47:0] OTH = 48'h021122334456;
    localparam logic [47:0] BCA = 48'hFFFFFFFFFFFF;
    localparam logic [47:0] MCA = 48'h01005E000001;
    localparam logic [47:0] SWP = 48'h110233224455;

    // {cfg(hash,promisc,enable), dest, set hash bit, exp accept, exp reason}
    localparam int NV = 14;
    localparam logic [55:0] VEC [NV] = '{
        {3'b001, STA, 1'b0, 1'b1, 3'd1},
        {3'b001, BCA, 1'b0, 1'b1, 3'd2},
        {3'b001, OTH, 1'b0, 1'b0, 3'd0},
        {3'b011, OTH, 1'b0, 1'b1, 3'd4},
        {3'b000, STA, 1'b0, 1'b0, 3'd5},
        {3'b010, BCA, 1'b0, 1'b0, 3'd5},
        {3'b101, MCA, 1'b1, 1'b1, 3'd3},
        {3'b101, MCA, 1'b0, 1'b0, 3'd0},
        {3'b001, MCA, 1'b1, 1'b0, 3'd0},
        {3'b101, STA, 1'b0, 1'b1, 3'd1},
        {3'b111, STA, 1'b0, 1'b1, 3'd4},
        {3'b101, BCA, 1'b0, 1'b1, 3'd2},
        {3'b001, SWP, 1'b0, 1'b0, 3'd0},
        {3'b101, OTH, 1'b1, 1'b1, 3'd3}
    };
    localparam string TAGS [NV] = '{
        "R4", "R5", "R8", "R3", "R2", "R2", "R6",
        "R7", "R8", "R4", "R3", "R5", "R4", "R6"
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] hash_of(input logic [47:0] d);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < 6; k++) begin
            logic [7:0] by = d[47-8*k -: 8];
            for (int j = 0; j < 8; j++) begin
                logic fb = c[0] ^ by[j];
                c = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
            end
        end
        return c[31:26];
    endfunction

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_addr = a; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic clear_hash();
        for (int a = 4; a < 8; a++) reg_write(3'(a), 32'h0);
    endtask

    task automatic send_frame(input logic [47:0] dest, input int extra, input bit gap,
                              input int wr_at, input logic [31:0] wr_dat,
                              output bit seen, output bit acc, output logic [2:0] rsn,
                              output bit early);
        early = 1'b0;
        for (int i = 0; i < 6; i++) begin
            if (gap && i == 3) begin
                @(negedge clk);
                rx_valid = 1'b0; rx_sof = 1'b0; cfg_wr_en = 1'b0;
            end
            @(negedge clk);
            if (flt_valid) early = 1'b1;
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = dest[47-8*i -: 8];
            cfg_wr_en = (i == wr_at); cfg_wr_addr = 3'd0; cfg_wr_data = wr_dat;
        end
        @(negedge clk);
        seen = flt_valid; acc = flt_accept; rsn = flt_reason;
        rx_valid = 1'b0; rx_sof = 1'b0; cfg_wr_en = 1'b0;
        for (int j = 0; j < extra; j++) begin
            rx_valid = 1'b1; rx_byte = 8'hFF - 8'(j);
            @(negedge clk);
        end
        rx_valid = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit seen, acc, early;
        logic [2:0] rsn;
        logic [5:0] hx;
        int p0;

        repeat (3) @(negedge clk);
        check(flt_valid == 1'b0, "R11", 32'(flt_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: nothing written yet, so receive is disabled
        send_frame(STA, 0, 0, -1, 0, seen, acc, rsn, early);
        check(seen && !acc && rsn == 3'd5, "R11", {seen, acc, rsn}, {1'b1, 1'b0, 3'd5});

        // R1: station words at addresses 1..3
        reg_write(3'd1, 32'hABCD_0211);
        reg_write(3'd2, 32'h0000_2233);
        reg_write(3'd3, 32'h0000_4455);

        for (int v = 0; v < NV; v++) begin
            logic [2:0]  cfg  = VEC[v][55:53];
            logic [47:0] dst  = VEC[v][52:5];
            logic        hset = VEC[v][4];
            logic        eacc = VEC[v][3];
            logic [2:0]  ersn = VEC[v][2:0];
            clear_hash();
            if (hset) begin
                hx = hash_of(dst);
                reg_write(3'(7 - hx[5:4]), 32'(1) << hx[3:0]);
            end
            reg_write(3'd0, {29'b0, cfg});
            send_frame(dst, 0, 0, -1, 0, seen, acc, rsn, early);
            check(seen && !early && acc == eacc && rsn == ersn, TAGS[v],
                  {early, seen, acc, rsn}, {1'b0, 1'b1, eacc, ersn});
        end

        // R7: bit placed in the mirrored register word has no effect
        clear_hash();
        hx = hash_of(MCA);
        reg_write(3'(4 + hx[5:4]), 32'(1) << hx[3:0]);
        reg_write(3'd0, 32'h5);
        send_frame(MCA, 0, 0, -1, 0, seen, acc, rsn, early);
        check(seen && !acc && rsn == 3'd0, "R7", {seen, acc, rsn}, {1'b1, 1'b0, 3'd0});
        // R7: a different bit in the right word has no effect either
        clear_hash();
        reg_write(3'(7 - hx[5:4]), 32'(1) << (hx[3:0] ^ 4'h1));
        send_frame(MCA, 0, 0, -1, 0, seen, acc, rsn, early);
        check(seen && !acc && rsn == 3'd0, "R7", {seen, acc, rsn}, {1'b1, 1'b0, 3'd0});
        clear_hash();

        // R9: trailing bytes give no second verdict; the strobe is one cycle
        reg_write(3'd0, 32'h1);
        p0 = pulses;
        send_frame(STA, 8, 0, -1, 0, seen, acc, rsn, early);
        repeat (3) @(negedge clk);
        check(seen && !early && rsn == 3'd1, "R9", {early, seen, rsn}, {1'b0, 1'b1, 3'd1});
        check(pulses - p0 == 1, "R9", 32'(pulses - p0), 1);

        // R9: an idle cycle between bytes only delays the verdict
        p0 = pulses;
        send_frame(BCA, 0, 1, -1, 0, seen, acc, rsn, early);
        @(negedge clk);
        check(seen && !early && acc && rsn == 3'd2, "R9", {early, seen, acc, rsn}, {1'b0, 1'b1, 1'b1, 3'd2});
        check(pulses - p0 == 1, "R9", 32'(pulses - p0), 1);

        // R10: disabling during a frame keeps the snapshot, applies next frame
        send_frame(STA, 0, 0, 3, 32'h0, seen, acc, rsn, early);
        check(seen && acc && rsn == 3'd1, "R10", {seen, acc, rsn}, {1'b1, 1'b1, 3'd1});
        send_frame(STA, 0, 0, -1, 0, seen, acc, rsn, early);
        check(seen && !acc && rsn == 3'd5, "R10", {seen, acc, rsn}, {1'b1, 1'b0, 3'd5});

        // R10: enabling promiscuous mid-frame does not rescue the current frame
        reg_write(3'd0, 32'h1);
        send_frame(OTH, 0, 0, 2, 32'h3, seen, acc, rsn, early);
        check(seen && !acc && rsn == 3'd0, "R10", {seen, acc, rsn}, {1'b1, 1'b0, 3'd0});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule